// File: doc/BRIEF.md
# Touch Key Controller Host Command Interface

This block sits between a host serial link and the sensing core of a 32-key touch controller laid out as 8 drive rows by 4 sense columns. A bit-level UART (9600 baud, 8 data bits, no parity, one stop bit, full duplex) lies outside the block. It hands received bytes in as single-cycle strobes and takes response bytes out through a valid/ready pair. The block parses an unterminated command grammar that mixes ASCII and binary. One-character commands finish on their first byte. Slash-prefixed commands finish once their fixed number of binary argument bytes has arrived.

A command can report the touch map or the fault map as four column bytes, an identity string, or the raw input pins. It can also look up one key's reference, signal, offset and cancellation values through a key-select output. Other commands read or write a byte-addressed settings store held inside the block, or drive an 8-bit output port. Per-key gain and threshold bytes share one 256-byte address space with a block of general user storage. Writing any gain byte raises a one-cycle recalibration request for the sensing core.

Top module: `touch_cmd_if`

## Requirements
- R1: 's' (0x73) returns 4 bytes. Byte k (k = 0..3, sent first to last) is column k, and its bit i is the touch state of row i, taken from `key_touch[8k+i]`.
- R2: 'e' (0x65) returns 4 bytes with the same byte and bit mapping as R1, taken from `key_error`.
- R3: 'S' (0x53) returns 7 ASCII bytes: "32000" followed by the two revision characters of parameter `REV_ID` (high byte first; default "11").
- R4: '/', 'd', X, Y (0x2F 0x64 X Y) drives `key_sel = {Y[1:0], X[2:0]}` and returns `key_ref`, then `key_sig`. Only the low bits of X and Y are used.
- R5: '/', 'D', X, Y (0x2F 0x44 X Y) selects the key as in R4 and returns `key_ofs`, then `{6'b0, key_coarse}`.
- R6: '/', 'e', A (0x2F 0x65 A) returns the stored byte at address A. Key (x, y), zero-based, keeps its gain at 100 + 2x + 16y and its threshold at the next address. User storage covers addresses 170..255. All stored bytes are 0 after reset.
- R7: '/', 'E', A, v (0x2F 0x45 A v) stores v at A. Addresses outside 100..163 and 170..255 ignore writes and read as 0x00.
- R8: A write to an even address in 100..163 (a gain byte) pulses `recal_req` high for exactly one cycle. Other writes leave it low.
- R9: 'O', v (0x4F v) sets `out_port` to v. 'I' (0x49) returns `{4'b0000, in_port}`. `out_port` is 0 after reset.
- R10: An unrecognised first byte is dropped. After '/', any byte other than 'd', 'D', 'e' or 'E' abandons the command. In both cases the next byte starts a new command.
- R11: A partly received multi-byte command is abandoned if no further byte arrives within `TIMEOUT_CYC` cycles. The next byte then starts a new command.
- R12: The first response byte is valid in the second cycle after the cycle that delivers the command's last byte. Each byte holds until `tx_ready` accepts it. Bytes received while a response is pending are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter accepts the current response byte |
| tx_valid | output | 1 | Response byte available |
| tx_data | output | 8 | Response byte |
| key_touch | input | 32 | Touch state, bit 8*column + row |
| key_error | input | 32 | Fault state, same layout |
| key_sel | output | 5 | Selected key {column, row} for value lookup |
| key_ref | input | 8 | Reference level of the selected key |
| key_sig | input | 8 | Signal level of the selected key |
| key_ofs | input | 8 | Offset setting of the selected key |
| key_coarse | input | 2 | Cancellation capacitor bits of the selected key |
| in_port | input | 4 | General input pins |
| out_port | output | 8 | General output pins |
| recal_req | output | 1 | One-cycle recalibration request |

## Verification
The final byte of a command is registered as a decoded command in the cycle that delivers it. On the next edge, that decoded command loads the response, the store, the output port and the recalibration flag together. The bench therefore drives each byte for one cycle between falling edges and samples at the falling edge right after the second rising edge. Checks of `tx_valid`, `out_port` and `recal_req` use that one point. Response bytes are then drained one per cycle with `tx_ready` high. The bench also confirms that no extra byte follows. The timeout check waits a little more than `TIMEOUT_CYC` idle cycles in one case and about half of it in the other. The byte sent after the wait shows which parser state was in effect.

// File: rtl/touch_cmd_pkg.sv
package touch_cmd_pkg;
  localparam int NUM_ROWS    = 8;
  localparam int NUM_COLS    = 4;
  localparam int NUM_KEYS    = NUM_ROWS * NUM_COLS;
  localparam int KEY_BASE    = 100;
  localparam int KEY_SPAN    = 2 * NUM_KEYS;
  localparam int USER_BASE   = 170;
  localparam int USER_SPAN   = 256 - USER_BASE;
  localparam int STORE_DEPTH = KEY_SPAN + USER_SPAN;
  localparam int STORE_AW    = $clog2(STORE_DEPTH);
  localparam int RESP_MAX    = 7;
  localparam int RESP_SLOTS  = 1 << $clog2(RESP_MAX + 1);
  localparam int RESP_LW     = $clog2(RESP_SLOTS);

  localparam logic [7:0] CH_STATE = 8'h73;
  localparam logic [7:0] CH_ERR   = 8'h65;
  localparam logic [7:0] CH_ID    = 8'h53;
  localparam logic [7:0] CH_IN    = 8'h49;
  localparam logic [7:0] CH_PORT  = 8'h4F;
  localparam logic [7:0] CH_SLASH = 8'h2F;
  localparam logic [7:0] CH_DATA  = 8'h64;
  localparam logic [7:0] CH_CAL   = 8'h44;
  localparam logic [7:0] CH_RD    = 8'h65;
  localparam logic [7:0] CH_WR    = 8'h45;

  typedef enum logic [3:0] {
    OP_NONE, OP_STATE, OP_ERR, OP_ID, OP_IN, OP_PORT, OP_DATA, OP_CAL, OP_RD, OP_WR
  } op_t;

  typedef struct packed {
    logic                hit;
    logic [STORE_AW-1:0] idx;
  } slot_t;

  // Byte address -> store slot; key settings first, user bytes after.
  function automatic slot_t map_addr(input logic [7:0] a);
    slot_t s;
    s.hit = 1'b0;
    s.idx = '0;
    if (a >= 8'(KEY_BASE) && a < 8'(KEY_BASE + KEY_SPAN)) begin
      s.hit = 1'b1;
      s.idx = STORE_AW'(a - 8'(KEY_BASE));
    end else if (a >= 8'(USER_BASE)) begin
      s.hit = 1'b1;
      s.idx = STORE_AW'(a - 8'(USER_BASE)) + STORE_AW'(KEY_SPAN);
    end
    return s;
  endfunction

  // Gain bytes are the even offsets inside the key-settings window.
  function automatic logic is_gain(input logic [7:0] a);
    logic [7:0] d;
    d = a - 8'(KEY_BASE);
    return (a >= 8'(KEY_BASE)) && (a < 8'(KEY_BASE + KEY_SPAN)) && !d[0];
  endfunction

  function automatic logic [4:0] key_index(input logic [7:0] x, input logic [7:0] y);
    return {y[1:0], x[2:0]};
  endfunction
endpackage

// File: rtl/touch_cmd_parser.sv
module touch_cmd_parser
  import touch_cmd_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       busy,
  output logic       cmd_go,
  output op_t        cmd_op,
  output logic [7:0] arg0,
  output logic [7:0] arg1,
  output logic       parser_idle,
  output logic       abandon
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [1:0] {PS_IDLE, PS_SLASH, PS_ARG} pstate_t;

  pstate_t       st;
  logic [1:0]    need, got;
  logic [TW-1:0] tmo;
  logic          accept;

  assign accept      = rx_valid && !busy;
  assign parser_idle = (st == PS_IDLE);
  assign abandon     = (st != PS_IDLE) && !accept && (tmo == TW'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PS_IDLE;
      cmd_op <= OP_NONE;
      arg0   <= '0;
      arg1   <= '0;
      need   <= '0;
      got    <= '0;
      tmo    <= '0;
      cmd_go <= 1'b0;
    end else begin
      cmd_go <= 1'b0;
      if (accept) begin
        tmo <= '0;
        case (st)
          PS_IDLE: begin
            got <= '0;
            case (rx_data)
              CH_STATE: begin cmd_op <= OP_STATE; cmd_go <= 1'b1; end
              CH_ERR:   begin cmd_op <= OP_ERR;   cmd_go <= 1'b1; end
              CH_ID:    begin cmd_op <= OP_ID;    cmd_go <= 1'b1; end
              CH_IN:    begin cmd_op <= OP_IN;    cmd_go <= 1'b1; end
              CH_PORT:  begin cmd_op <= OP_PORT;  need <= 2'd1; st <= PS_ARG; end
              CH_SLASH: st <= PS_SLASH;
              default:  ;
            endcase
          end
          PS_SLASH: begin
            st <= PS_ARG;
            case (rx_data)
              CH_DATA: begin cmd_op <= OP_DATA; need <= 2'd2; end
              CH_CAL:  begin cmd_op <= OP_CAL;  need <= 2'd2; end
              CH_RD:   begin cmd_op <= OP_RD;   need <= 2'd1; end
              CH_WR:   begin cmd_op <= OP_WR;   need <= 2'd2; end
              default: st <= PS_IDLE;
            endcase
          end
          PS_ARG: begin
            if (got == 2'd0) arg0 <= rx_data;
            else             arg1 <= rx_data;
            got <= got + 2'd1;
            if (got + 2'd1 == need) begin
              cmd_go <= 1'b1;
              st     <= PS_IDLE;
            end
          end
          default: st <= PS_IDLE;
        endcase
      end else if (abandon) begin
        st  <= PS_IDLE;
        tmo <= '0;
      end else if (st != PS_IDLE) begin
        tmo <= tmo + TW'(1);
      end
    end
  end
endmodule

// File: rtl/touch_cmd_store.sv
module touch_cmd_store
  import touch_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] waddr,
  input  logic [7:0] wdata,
  input  logic [7:0] raddr,
  output logic [7:0] rdata,
  output logic       recal_req
);
  logic [7:0] mem [STORE_DEPTH];
  slot_t      ws, rs;

  assign ws = map_addr(waddr);
  assign rs = map_addr(raddr);
  assign rdata = rs.hit ? mem[rs.idx] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STORE_DEPTH; i++) mem[i] <= '0;
      recal_req <= 1'b0;
    end else begin
      if (we && ws.hit) mem[ws.idx] <= wdata;
      recal_req <= we && is_gain(waddr);
    end
  end
endmodule

// File: rtl/touch_cmd_tx.sv
module touch_cmd_tx
  import touch_cmd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [RESP_MAX*8-1:0] load_bytes,
  input  logic [RESP_LW-1:0]    load_len,
  input  logic                  tx_ready,
  output logic                  tx_valid,
  output logic [7:0]            tx_data,
  output logic                  busy
);
  logic [7:0]         hold_q [RESP_SLOTS];
  logic [RESP_LW-1:0] idx, len;

  assign tx_valid = (idx < len);
  assign busy     = tx_valid;
  assign tx_data  = tx_valid ? hold_q[idx] : 8'h00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < RESP_SLOTS; i++) hold_q[i] <= '0;
      idx <= '0;
      len <= '0;
    end else if (load) begin
      for (int i = 0; i < RESP_MAX; i++) hold_q[i] <= load_bytes[i*8 +: 8];
      idx <= '0;
      len <= load_len;
    end else if (tx_valid && tx_ready) begin
      idx <= idx + RESP_LW'(1);
    end
  end
endmodule

// File: rtl/touch_cmd_if.sv
module touch_cmd_if
  import touch_cmd_pkg::*;
#(
  parameter int          TIMEOUT_CYC = 1000,
  parameter logic [15:0] REV_ID      = 16'h3131
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic [31:0] key_touch,
  input  logic [31:0] key_error,
  output logic [4:0]  key_sel,
  input  logic [7:0]  key_ref,
  input  logic [7:0]  key_sig,
  input  logic [7:0]  key_ofs,
  input  logic [1:0]  key_coarse,
  input  logic [3:0]  in_port,
  output logic [7:0]  out_port,
  output logic        recal_req
);
  logic                  cmd_go, parser_idle, abandon, tx_busy, busy;
  op_t                   cmd_op;
  logic [7:0]            arg0, arg1, rdata;
  logic [RESP_MAX*8-1:0] resp;
  logic [RESP_LW-1:0]    rlen;

  assign busy    = tx_busy || cmd_go;
  assign key_sel = key_index(arg0, arg1);

  touch_cmd_parser #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_parser (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .busy(busy),
    .cmd_go(cmd_go), .cmd_op(cmd_op), .arg0(arg0), .arg1(arg1),
    .parser_idle(parser_idle), .abandon(abandon)
  );

  touch_cmd_store u_store (
    .clk(clk), .rst_n(rst_n), .we(cmd_go && cmd_op == OP_WR), .waddr(arg0), .wdata(arg1),
    .raddr(arg0), .rdata(rdata), .recal_req(recal_req)
  );

  always_comb begin
    resp = '0;
    rlen = '0;
    case (cmd_op)
      OP_STATE: begin resp[31:0] = key_touch; rlen = RESP_LW'(4); end
      OP_ERR:   begin resp[31:0] = key_error; rlen = RESP_LW'(4); end
      OP_ID:    begin
        resp = {REV_ID[7:0], REV_ID[15:8], 8'h30, 8'h30, 8'h30, 8'h32, 8'h33};
        rlen = RESP_LW'(7);
      end
      OP_IN:    begin resp[7:0]  = {4'b0000, in_port};        rlen = RESP_LW'(1); end
      OP_DATA:  begin resp[15:0] = {key_sig, key_ref};         rlen = RESP_LW'(2); end
      OP_CAL:   begin resp[15:0] = {6'b0, key_coarse, key_ofs}; rlen = RESP_LW'(2); end
      OP_RD:    begin resp[7:0]  = rdata;                      rlen = RESP_LW'(1); end
      default:  ;
    endcase
  end

  touch_cmd_tx u_tx (
    .clk(clk), .rst_n(rst_n), .load(cmd_go && rlen != '0), .load_bytes(resp), .load_len(rlen),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .busy(tx_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          out_port <= '0;
    else if (cmd_go && cmd_op == OP_PORT) out_port <= arg0;
  end
endmodule

// File: rtl/touch_cmd_chk.sv
module touch_cmd_chk
  import touch_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_go,
  input op_t        cmd_op,
  input logic       parser_idle,
  input logic       abandon,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic [7:0] out_port,
  input logic       recal_req
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R12
  AST_STATE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && cmd_op == OP_STATE |=> tx_valid); // R12
  AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go |=> !cmd_go); // R1
  AST_PORT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_go && cmd_op == OP_PORT) |=> $stable(out_port)); // R9
  AST_IN_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && cmd_op == OP_IN |=> tx_valid && tx_data[7:4] == 4'h0); // R9
  AST_RECAL_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |-> $past(cmd_go && cmd_op == OP_WR)); // R8
  AST_RECAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    recal_req |=> !recal_req); // R8
  AST_ABANDON_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abandon |=> parser_idle); // R11
endmodule

bind touch_cmd_if touch_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_op(cmd_op), .parser_idle(parser_idle),
  .abandon(abandon), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .out_port(out_port), .recal_req(recal_req)
);

// File: tb/touch_cmd_if_bench.sv
`timescale 1ns/1ps
module touch_cmd_if_bench;
  localparam int TMO = 1000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tx_ready = 1'b0;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic [31:0] key_touch = '0, key_error = '0;
  logic [4:0]  key_sel;
  logic [7:0]  key_ref, key_sig, key_ofs, out_port;
  logic [1:0]  key_coarse;
  logic [3:0]  in_port = '0;
  logic        recal_req;
  int          checks = 0, fails = 0;
  logic [7:0]  model [256];

  always #2.5 clk = ~clk;

  function automatic logic [7:0] f_ref(input logic [4:0] s);
    return {s, 3'b101};
  endfunction
  function automatic logic [7:0] f_sig(input logic [4:0] s);
    return 8'hFF - 8'(s) * 8'd3;
  endfunction
  function automatic logic [7:0] f_ofs(input logic [4:0] s);
    return 8'(s) * 8'd5 + 8'd7;
  endfunction
  function automatic logic [1:0] f_coarse(input logic [4:0] s);
    return (s[1:0] == 2'd2) ? 2'd3 : s[1:0];
  endfunction
  function automatic bit addr_ok(input int a);
    return (a >= 100 && a < 164) || (a >= 170 && a <= 255);
  endfunction
  function automatic bit addr_gain(input int a);
    return a >= 100 && a < 164 && (a % 2 == 0);
  endfunction
  function automatic int set_addr(input int x, input int y);
    return 100 + 2 * x + 16 * y;
  endfunction

  assign key_ref    = f_ref(key_sel);
  assign key_sig    = f_sig(key_sel);
  assign key_ofs    = f_ofs(key_sel);
  assign key_coarse = f_coarse(key_sel);

  touch_cmd_if #(.TIMEOUT_CYC(TMO)) u_touch_cmd_if (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .key_touch(key_touch), .key_error(key_error),
    .key_sel(key_sel), .key_ref(key_ref), .key_sig(key_sig), .key_ofs(key_ofs),
    .key_coarse(key_coarse), .in_port(in_port), .out_port(out_port), .recal_req(recal_req)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic expect_resp(input string req, input int n, input logic [63:0] e);
    logic [63:0] r;
    int got, guard;
    logic extra;
    r = '0; got = 0; guard = 0; extra = 1'b0;
    tx_ready = 1'b1;
    while (got < n && guard < 200) begin
      if (tx_valid) begin r[got*8 +: 8] = tx_data; got++; end
      @(negedge clk); guard++;
    end
    tx_ready = 1'b0;
    check({req, " count"}, 64'(got), 64'(n));
    for (int i = 0; i < n; i++) check({req, " byte"}, 64'(r[i*8 +: 8]), 64'(e[i*8 +: 8]));
    repeat (3) begin @(negedge clk); extra |= tx_valid; end
    check({req, " no extra"}, 64'(extra), 64'(0));
  endtask

  task automatic wr(input int a, input logic [7:0] v);
    send(8'h2F); send(8'h45); send(8'(a)); send(v);
    if (addr_ok(a)) model[a] = v;
  endtask

  task automatic rd_check(input string req, input int a);
    send(8'h2F); send(8'h65); send(8'(a));
    expect_resp(req, 1, 64'(model[a]));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R12 reset tx_valid", 64'(tx_valid), 0);
    check("R9 reset out_port", 64'(out_port), 0);
    check("R8 reset recal_req", 64'(recal_req), 0);
    rd_check("R6 reset store", 100);

    // R12 latency with 'I', R9 input format
    in_port = 4'hA;
    send(8'h49);
    check("R12 not yet valid", 64'(tx_valid), 0);
    @(negedge clk);
    check("R12 valid second cycle", 64'(tx_valid), 1);
    expect_resp("R9 input read", 1, 64'h0A);

    // R1 key X5/Y2 -> byte 1 bit 4
    key_touch = 32'h0000_1000;
    send(8'h73);
    expect_resp("R1 single key", 4, 64'h0000_1000);

    // R3 identity
    send(8'h53);
    expect_resp("R3 identity", 7, {8'h00, "11", "000", "2", "3"} );

    // R10 unknown bytes dropped
    in_port = 4'h5;
    send(8'h41); send(8'h49);
    expect_resp("R10 unknown first byte", 1, 64'h05);
    send(8'h2F); send(8'h78); send(8'h49);
    expect_resp("R10 unknown after slash", 1, 64'h05);

    // R6/R8 gain and threshold of key X6/Y3 (x=5, y=2)
    wr(set_addr(5, 2), 8'h5A);
    @(negedge clk);
    check("R8 gain write pulse", 64'(recal_req), 1);
    @(negedge clk);
    check("R8 pulse one cycle", 64'(recal_req), 0);
    wr(set_addr(5, 2) + 1, 8'h33);
    @(negedge clk);
    check("R8 threshold no pulse", 64'(recal_req), 0);
    rd_check("R6 gain readback", 142);
    rd_check("R6 threshold readback", 143);
    wr(170, 8'h77);
    @(negedge clk);
    check("R8 user write no pulse", 64'(recal_req), 0);
    wr(255, 8'h88);
    rd_check("R6 user first", 170);
    rd_check("R6 user last", 255);
    wr(99, 8'h44);  rd_check("R7 below window", 99);
    wr(164, 8'h45); rd_check("R7 gap low", 164);
    wr(169, 8'h46); rd_check("R7 gap high", 169);

    // R9 output port
    send(8'h4F); send(8'hC3);
    @(negedge clk);
    check("R9 out_port", 64'(out_port), 64'hC3);

    // R11 timeout: expired vs not expired
    in_port = 4'hA;
    send(8'h2F); send(8'h65);
    repeat (TMO + 5) @(negedge clk);
    send(8'h49);
    expect_resp("R11 abandoned after timeout", 1, 64'h0A);
    send(8'h2F); send(8'h65);
    repeat (TMO / 2) @(negedge clk);
    send(8'd170);
    expect_resp("R11 kept within timeout", 1, 64'h77);

    // R12 bytes dropped while response pending
    key_touch = 32'hDEAD_BEEF;
    send(8'h73); send(8'h49);
    expect_resp("R12 drop while busy", 4, 64'hDEAD_BEEF);

    // random mix
    for (int it = 0; it < 250; it++) begin
      int kind, a;
      logic [7:0] x, y, v;
      logic [4:0] s;
      kind = int'($urandom % 8);
      x = 8'($urandom); y = 8'($urandom); v = 8'($urandom);
      key_touch = $urandom; key_error = $urandom; in_port = 4'($urandom);
      s = {y[1:0], x[2:0]};
      case (kind)
        0: begin send(8'h73); expect_resp("R1 random", 4, 64'(key_touch)); end
        1: begin send(8'h65); expect_resp("R2 random", 4, 64'(key_error)); end
        2: begin send(8'h2F); send(8'h64); send(x); send(y);
                 expect_resp("R4 random", 2, 64'({f_sig(s), f_ref(s)})); end
        3: begin send(8'h2F); send(8'h44); send(x); send(y);
                 expect_resp("R5 random", 2, 64'({6'b0, f_coarse(s), f_ofs(s)})); end
        4: begin
          a = (it % 2 == 0) ? 100 + int'($urandom % 156) : int'($urandom % 256);
          wr(a, v);
          @(negedge clk);
          check("R8 random write pulse", 64'(recal_req), 64'(addr_gain(a)));
        end
        5: begin
          a = (it % 2 == 0) ? 100 + int'($urandom % 156) : int'($urandom % 256);
          rd_check(addr_ok(a) ? "R6 random read" : "R7 random read", a);
        end
        6: begin send(8'h4F); send(v); @(negedge clk);
                 check("R9 random port", 64'(out_port), 64'(v)); end
        default: begin send(8'h49); expect_resp("R9 random input", 1, 64'({4'b0, in_port})); end
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule